// File: doc/BRIEF.md
# Load-Based Packet Latency Estimator

This block replaces a detailed on-chip network model with a fast estimate. A packet descriptor gives a source node, a destination node and a size in flits. The block works out which routers of a 2D mesh the packet would cross under X-first, Y-second routing. Every router on that path looks up a delay in its own table, indexed by the load the router currently carries. The partial delays are summed, and the descriptor leaves tagged with the total. The packet is never stored inside the model. The only state that changes over time is one load counter per router, and each router the packet crosses has that counter raised by the packet's size.

Each router holds two curves. The injection curve is used only at the router attached to the source node. The network curve is used at every other router on the path, including the destination. A separate write port fills both curves before traffic starts, and can rewrite them between bursts. Descriptors come from an upstream FIFO (valid/pop) and go to a downstream FIFO (full/push). The pipeline has two register stages and accepts one descriptor per cycle unless the output FIFO is full.

Top module: `lbe_estimator`

## Requirements
- R1: Reset is synchronous and active low. While it is held, `in_pop` and `out_push` stay low. After reset every router load is zero, so the first lookups use curve entry 0.
- R2: A packet's path starts at its source, runs along the source row to the destination column, then runs along that column to the destination. Node id = y*MESH_X + x. Routers off the path add no delay and gain no load.
- R3: The source router contributes its injection-curve entry, and every other router on the path contributes its network-curve entry. A descriptor with source equal to destination contributes only the injection entry of that router.
- R4: `out_latency` is the exact sum of all partial delays, in DELAY_W + clog2(routers) bits, so it cannot overflow.
- R5: A packet's lookups use each router's load including every earlier accepted packet, even the packet accepted in the previous cycle, and excluding the packet itself. Each router on the path then gains the packet's size.
- R6: The lookup index is the load clipped to the last table entry (2^CURVE_AW - 1, which is 15 by default). A load counter stops at 2^LOAD_W - 1 (1023 by default) and never wraps.
- R7: Without backpressure one descriptor is popped every cycle. A descriptor popped in the cycle before clock edge k is pushed in the cycle after edge k+1.
- R8: While `out_full` is high and a result is waiting, nothing is pushed, nothing new enters once both stages are occupied, the waiting output stays unchanged, and no load is committed for it.
- R9: When `cw_en` is high, a clock edge writes `cw_data` to entry `cw_addr` of router `cw_router`. `cw_inj`=1 selects the injection curve and `cw_inj`=0 selects the network curve. Lookups from the next cycle on see the new value.
- R10: `in_pop` is high only when `in_valid` is high, and `out_push` is high only when `out_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input FIFO holds a descriptor |
| in_pop | output | 1 | Take the descriptor this cycle |
| in_src | input | NODE_W | Source node id |
| in_dst | input | NODE_W | Destination node id |
| in_size | input | SIZE_W | Packet size in flits |
| out_full | input | 1 | Output FIFO cannot accept |
| out_push | output | 1 | Write the tagged descriptor |
| out_src | output | NODE_W | Source node of the result |
| out_dst | output | NODE_W | Destination node of the result |
| out_size | output | SIZE_W | Size of the result |
| out_latency | output | SUM_W | Estimated total latency |
| cw_en | input | 1 | Curve write strobe |
| cw_inj | input | 1 | 1 selects the injection curve, 0 the network curve |
| cw_router | input | NODE_W | Router whose curve is written |
| cw_addr | input | CURVE_AW | Curve entry index |
| cw_data | input | DELAY_W | Delay value written |

## Verification
The embedded assertions check the handshake rules on every cycle: a push only into a non-full FIFO, a pop only from a non-empty one, a held output and no new pop during a stall, and an accepted descriptor reaching the routing stage. They also check that the routing stage marks exactly one injection router on the path and includes the destination, and that no router's load ever drops or changes while the router is not committing. The correctness of each estimated latency can only be shown by the bench's scenarios. That covers the exact path sums, forwarding between back-to-back packets, index clipping, counter saturation after long runs, curve rewrites and the deferred commit during a stall. The bench compares each result against its own step-by-step walk of the mesh.

// File: rtl/lbe_pkg.sv
package lbe_pkg;

  // True when router (x,y) lies on the X-first, Y-second route from (sx,sy) to (dx,dy)
  function automatic bit on_xy_path(int x, int y, int sx, int sy, int dx, int dy);
    int xlo;
    int xhi;
    int ylo;
    int yhi;
    bit row_leg;
    bit col_leg;
    xlo = (sx < dx) ? sx : dx;
    xhi = (sx < dx) ? dx : sx;
    ylo = (sy < dy) ? sy : dy;
    yhi = (sy < dy) ? dy : sy;
    row_leg = (y == sy) && (x >= xlo) && (x <= xhi);
    col_leg = (x == dx) && (y >= ylo) && (y <= yhi);
    return row_leg || col_leg;
  endfunction

  // Addition that sticks at lim instead of wrapping
  function automatic int sat_add(int a, int b, int lim);
    return (a + b > lim) ? lim : a + b;
  endfunction

  // Clip a load value to the last table index
  function automatic int clip_index(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/lbe_route.sv
module lbe_route #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int NODE_W = 4,
  parameter int SIZE_W = 4,
  localparam int N = MESH_X * MESH_Y
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              in_valid,
  input  logic [NODE_W-1:0] in_src,
  input  logic [NODE_W-1:0] in_dst,
  input  logic [SIZE_W-1:0] in_size,
  output logic              r1_valid,
  output logic [NODE_W-1:0] r1_src,
  output logic [NODE_W-1:0] r1_dst,
  output logic [SIZE_W-1:0] r1_size,
  output logic [N-1:0]      r1_path,
  output logic [N-1:0]      r1_inj
);

  logic [N-1:0] path_c;
  logic [N-1:0] inj_c;

  always_comb begin
    int sx;
    int sy;
    int dx;
    int dy;
    sx = int'(in_src) % MESH_X;
    sy = int'(in_src) / MESH_X;
    dx = int'(in_dst) % MESH_X;
    dy = int'(in_dst) / MESH_X;
    for (int r = 0; r < N; r++) begin
      path_c[r] = lbe_pkg::on_xy_path(r % MESH_X, r / MESH_X, sx, sy, dx, dy);
      inj_c[r]  = (r == int'(in_src));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1_valid <= 1'b0;
      r1_src   <= '0;
      r1_dst   <= '0;
      r1_size  <= '0;
      r1_path  <= '0;
      r1_inj   <= '0;
    end else if (advance) begin
      r1_valid <= in_valid;
      if (in_valid) begin
        r1_src  <= in_src;
        r1_dst  <= in_dst;
        r1_size <= in_size;
        r1_path <= path_c;
        r1_inj  <= inj_c;
      end
    end
  end

  // R3: exactly one injection router, and it sits on the path
  a_r3_single_injector: assert property (@(posedge clk) disable iff (!rst_n)
    r1_valid |-> ($countones(r1_inj) == 1 && (r1_inj & ~r1_path) == '0));

  // R2: the destination router is always part of the path
  a_r2_dest_on_path: assert property (@(posedge clk) disable iff (!rst_n)
    r1_valid |-> r1_path[r1_dst]);

endmodule

// File: rtl/lbe_load_track.sv
module lbe_load_track #(
  parameter int N      = 16,
  parameter int LOAD_W = 10,
  parameter int SIZE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pend_valid,
  input  logic                         commit,
  input  logic [N-1:0]                 pend_mask,
  input  logic [SIZE_W-1:0]            pend_size,
  output logic [N-1:0][LOAD_W-1:0]     eff_load
);

  localparam int LOAD_MAX = (1 << LOAD_W) - 1;

  logic [N-1:0][LOAD_W-1:0] load_q;
  logic [N-1:0][LOAD_W-1:0] load_plus;

  always_comb begin
    for (int r = 0; r < N; r++) begin
      load_plus[r] = LOAD_W'(lbe_pkg::sat_add(int'(load_q[r]), int'(pend_size), LOAD_MAX));
      // forward the packet that has looked up but not yet committed
      eff_load[r]  = (pend_valid && pend_mask[r]) ? load_plus[r] : load_q[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        if (commit && pend_mask[r]) load_q[r] <= load_plus[r];
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_chk
    // R6: a counter never wraps back to a smaller value
    a_r6_load_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      load_q[r] >= $past(load_q[r]));
    // R2 / R8: a router changes only when a packet on its path commits
    a_r2_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && pend_mask[r]) |=> $stable(load_q[r]));
  end

endmodule

// File: rtl/lbe_curve_bank.sv
module lbe_curve_bank #(
  parameter int N        = 16,
  parameter int CURVE_AW = 4,
  parameter int DELAY_W  = 16,
  parameter int LOAD_W   = 10,
  parameter int RID_W    = 4
) (
  input  logic                         clk,
  input  logic                         cw_en,
  input  logic                         cw_inj,
  input  logic [RID_W-1:0]             cw_router,
  input  logic [CURVE_AW-1:0]          cw_addr,
  input  logic [DELAY_W-1:0]           cw_data,
  input  logic [N-1:0][LOAD_W-1:0]     eff_load,
  output logic [N-1:0][DELAY_W-1:0]    net_delay,
  output logic [N-1:0][DELAY_W-1:0]    inj_delay
);

  localparam int DEPTH = 1 << CURVE_AW;

  for (genvar r = 0; r < N; r++) begin : g_router
    logic [DELAY_W-1:0]  net_mem [DEPTH];
    logic [DELAY_W-1:0]  inj_mem [DEPTH];
    logic [CURVE_AW-1:0] idx;
    logic                sel_me;

    assign sel_me = cw_en && (cw_router == RID_W'(r));
    assign idx    = CURVE_AW'(lbe_pkg::clip_index(int'(eff_load[r]), DEPTH - 1));

    always_ff @(posedge clk) begin
      if (sel_me) begin
        if (cw_inj) inj_mem[cw_addr] <= cw_data;
        else        net_mem[cw_addr] <= cw_data;
      end
    end

    assign net_delay[r] = net_mem[idx];
    assign inj_delay[r] = inj_mem[idx];
  end

endmodule

// File: rtl/lbe_sum_tree.sv
module lbe_sum_tree #(
  parameter int N     = 16,
  parameter int IN_W  = 16,
  parameter int OUT_W = 20
) (
  input  logic [N-1:0][IN_W-1:0] terms,
  output logic [OUT_W-1:0]       total
);

  localparam int LV = $clog2(N);
  localparam int P  = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int W = P >> l;
    logic [OUT_W-1:0] s [W];
    for (genvar i = 0; i < W; i++) begin : g_n
      if (l == 0 && i < N) begin : g_leaf
        assign s[i] = OUT_W'(terms[i]);
      end else if (l == 0) begin : g_pad
        assign s[i] = '0;
      end else begin : g_add
        assign s[i] = g_lv[l-1].s[2*i] + g_lv[l-1].s[2*i+1];
      end
    end
  end

  assign total = g_lv[LV].s[0];

endmodule

// File: rtl/lbe_estimator.sv
module lbe_estimator #(
  parameter int MESH_X   = 4,
  parameter int MESH_Y   = 4,
  parameter int SIZE_W   = 4,
  parameter int LOAD_W   = 10,
  parameter int CURVE_AW = 4,
  parameter int DELAY_W  = 16,
  localparam int N       = MESH_X * MESH_Y,
  localparam int NODE_W  = (N > 1) ? $clog2(N) : 1,
  localparam int SUM_W   = DELAY_W + $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_pop,
  input  logic [NODE_W-1:0]   in_src,
  input  logic [NODE_W-1:0]   in_dst,
  input  logic [SIZE_W-1:0]   in_size,
  input  logic                out_full,
  output logic                out_push,
  output logic [NODE_W-1:0]   out_src,
  output logic [NODE_W-1:0]   out_dst,
  output logic [SIZE_W-1:0]   out_size,
  output logic [SUM_W-1:0]    out_latency,
  input  logic                cw_en,
  input  logic                cw_inj,
  input  logic [NODE_W-1:0]   cw_router,
  input  logic [CURVE_AW-1:0] cw_addr,
  input  logic [DELAY_W-1:0]  cw_data
);

  // named pipeline events, used by the assertions
  logic advance;
  logic stall_evt;

  logic              r1_valid;
  logic [NODE_W-1:0] r1_src;
  logic [NODE_W-1:0] r1_dst;
  logic [SIZE_W-1:0] r1_size;
  logic [N-1:0]      r1_path;
  logic [N-1:0]      r1_inj;

  logic                       r2_valid;
  logic [NODE_W-1:0]          r2_src;
  logic [NODE_W-1:0]          r2_dst;
  logic [SIZE_W-1:0]          r2_size;
  logic [N-1:0]               r2_path;
  logic [N-1:0][DELAY_W-1:0]  r2_part;

  logic [N-1:0][LOAD_W-1:0]   eff_load;
  logic [N-1:0][DELAY_W-1:0]  net_delay;
  logic [N-1:0][DELAY_W-1:0]  inj_delay;
  logic [N-1:0][DELAY_W-1:0]  partial;

  assign advance   = !r2_valid || !out_full;
  assign stall_evt = r2_valid && out_full;
  assign in_pop    = rst_n && in_valid && advance;
  assign out_push  = r2_valid && !out_full;

  lbe_route #(
    .MESH_X (MESH_X),
    .MESH_Y (MESH_Y),
    .NODE_W (NODE_W),
    .SIZE_W (SIZE_W)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .in_valid (in_valid),
    .in_src   (in_src),
    .in_dst   (in_dst),
    .in_size  (in_size),
    .r1_valid (r1_valid),
    .r1_src   (r1_src),
    .r1_dst   (r1_dst),
    .r1_size  (r1_size),
    .r1_path  (r1_path),
    .r1_inj   (r1_inj)
  );

  lbe_load_track #(
    .N      (N),
    .LOAD_W (LOAD_W),
    .SIZE_W (SIZE_W)
  ) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_valid (r2_valid),
    .commit     (out_push),
    .pend_mask  (r2_path),
    .pend_size  (r2_size),
    .eff_load   (eff_load)
  );

  lbe_curve_bank #(
    .N        (N),
    .CURVE_AW (CURVE_AW),
    .DELAY_W  (DELAY_W),
    .LOAD_W   (LOAD_W),
    .RID_W    (NODE_W)
  ) u_curves (
    .clk       (clk),
    .cw_en     (cw_en),
    .cw_inj    (cw_inj),
    .cw_router (cw_router),
    .cw_addr   (cw_addr),
    .cw_data   (cw_data),
    .eff_load  (eff_load),
    .net_delay (net_delay),
    .inj_delay (inj_delay)
  );

  // source router takes the injection curve; the rest of the path the network curve
  always_comb begin
    for (int r = 0; r < N; r++) begin
      if (r1_inj[r])       partial[r] = inj_delay[r];
      else if (r1_path[r]) partial[r] = net_delay[r];
      else                 partial[r] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r2_valid <= 1'b0;
      r2_src   <= '0;
      r2_dst   <= '0;
      r2_size  <= '0;
      r2_path  <= '0;
      r2_part  <= '0;
    end else if (advance) begin
      r2_valid <= r1_valid;
      r2_src   <= r1_src;
      r2_dst   <= r1_dst;
      r2_size  <= r1_size;
      r2_path  <= r1_valid ? r1_path : '0;
      r2_part  <= partial;
    end
  end

  lbe_sum_tree #(
    .N     (N),
    .IN_W  (DELAY_W),
    .OUT_W (SUM_W)
  ) u_sum (
    .terms (r2_part),
    .total (out_latency)
  );

  assign out_src  = r2_src;
  assign out_dst  = r2_dst;
  assign out_size = r2_size;

  // R10: handshake rules at both FIFO edges
  a_r10_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full);
  a_r10_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> in_valid);

  // R8: a blocked result stays put, and a full pipeline takes nothing new
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> (r2_valid && $stable(out_latency) && $stable(out_src) && $stable(out_dst)));
  a_r8_no_pop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_evt && r1_valid) |-> !in_pop);

  // R7: an accepted descriptor occupies the routing stage next cycle
  a_r7_pop_to_route: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |=> r1_valid);

endmodule

// File: tb/lbe_estimator_test.sv
`timescale 1ns/1ps
module lbe_estimator_test;

  localparam int MX = 4;
  localparam int NR = 16;
  localparam int TOP_IDX = 15;
  localparam int LOAD_CAP = 1023;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_pop;
  logic [3:0]  in_src, in_dst, in_size;
  logic        out_full;
  logic        out_push;
  logic [3:0]  out_src, out_dst, out_size;
  logic [19:0] out_latency;
  logic        cw_en, cw_inj;
  logic [3:0]  cw_router, cw_addr;
  logic [15:0] cw_data;

  always #10 clk = ~clk;

  lbe_estimator uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pop(in_pop),
    .in_src(in_src), .in_dst(in_dst), .in_size(in_size),
    .out_full(out_full), .out_push(out_push), .out_src(out_src),
    .out_dst(out_dst), .out_size(out_size), .out_latency(out_latency),
    .cw_en(cw_en), .cw_inj(cw_inj), .cw_router(cw_router),
    .cw_addr(cw_addr), .cw_data(cw_data)
  );

  typedef struct { int src; int dst; int size; int lat; int tk; } exp_t;
  exp_t expq[$];

  int net_tab [NR][16];
  int inj_tab [NR][16];
  int mload [NR];
  int checks = 0;
  int errors = 0;
  int tick_no = 0;
  bit popped;
  bit finished = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int idx_of(int ld);
    return (ld > TOP_IDX) ? TOP_IDX : ld;
  endfunction

  function automatic void bump(int r, int sz);
    mload[r] = (mload[r] + sz > LOAD_CAP) ? LOAD_CAP : mload[r] + sz;
  endfunction

  // walk the mesh step by step, X first then Y
  function automatic int model_packet(int s, int d, int sz);
    int x, y, dx, dy, r, lat;
    x = s % MX; y = s / MX; dx = d % MX; dy = d / MX;
    lat = inj_tab[s][idx_of(mload[s])];
    bump(s, sz);
    while (x != dx) begin
      x += (dx > x) ? 1 : -1;
      r = y * MX + x;
      lat += net_tab[r][idx_of(mload[r])];
      bump(r, sz);
    end
    while (y != dy) begin
      y += (dy > y) ? 1 : -1;
      r = y * MX + x;
      lat += net_tab[r][idx_of(mload[r])];
      bump(r, sz);
    end
    return lat;
  endfunction

  task automatic observe();
    exp_t e;
    if (out_push) begin
      if (expq.size() == 0) chk(cur_tag, "unexpected push", 1, 0);
      else begin
        e = expq.pop_front();
        chk(cur_tag, "latency (R4 sum)", int'(out_latency), e.lat);
        chk(cur_tag, "src", int'(out_src), e.src);
        chk(cur_tag, "dst", int'(out_dst), e.dst);
        chk("R7", "pop-to-push cycles", tick_no - e.tk, 2);
      end
    end
    if (in_pop) begin
      e.src = int'(in_src); e.dst = int'(in_dst); e.size = int'(in_size);
      e.lat = model_packet(e.src, e.dst, e.size);
      e.tk = tick_no;
      expq.push_back(e);
      popped = 1'b1;
    end
  endtask

  task automatic tick();
    #1;
    observe();
    tick_no++;
    @(negedge clk);
  endtask

  task automatic write_curve(bit inj, int r, int a, int v);
    cw_en = 1'b1; cw_inj = inj; cw_router = 4'(r); cw_addr = 4'(a); cw_data = 16'(v);
    if (inj) inj_tab[r][a] = v; else net_tab[r][a] = v;
    tick();
    cw_en = 1'b0;
  endtask

  task automatic send(int s, int d, int sz, output int waited);
    in_valid = 1'b1; in_src = 4'(s); in_dst = 4'(d); in_size = 4'(sz);
    waited = 0;
    popped = 1'b0;
    while (!popped && waited < 50) begin
      tick();
      waited++;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (5) tick();
    chk(cur_tag, "results outstanding after drain", expq.size(), 0);
  endtask

  task automatic t_reset();
    cur_tag = "R1";
    rst_n = 1'b0; in_valid = 1'b1; in_src = 4'd0; in_dst = 4'd5; in_size = 4'd1;
    out_full = 1'b0; cw_en = 1'b0; cw_inj = 1'b0; cw_router = '0; cw_addr = '0; cw_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "in_pop during reset", int'(in_pop), 0);
    chk("R1", "out_push during reset", int'(out_push), 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int r = 0; r < NR; r++) mload[r] = 0;
    #1;
    chk("R10", "in_pop with empty input", int'(in_pop), 0);
    chk("R1", "out_push after reset", int'(out_push), 0);
    @(negedge clk);
  endtask

  task automatic t_fill();
    cur_tag = "R9";
    for (int r = 0; r < NR; r++)
      for (int a = 0; a < 16; a++) begin
        write_curve(1'b0, r, a, 10 + r * 7 + a * 3);
        write_curve(1'b1, r, a, 200 + r * 5 + a * 11);
      end
  endtask

  task automatic t_self();
    int w;
    cur_tag = "R3";
    send(0, 0, 1, w);   // first use at load zero (R1), injection only (R3)
    drain();
  endtask

  task automatic t_paths();
    int w;
    cur_tag = "R2";
    send(1, 14, 2, w);  // east then south
    drain();
    send(11, 4, 3, w);  // west then north
    drain();
    send(12, 3, 1, w);  // east then north
    drain();
  endtask

  task automatic t_forward();
    int w;
    cur_tag = "R5";
    for (int i = 0; i < 4; i++) send(3, 7, 3, w);
    send(7, 3, 2, w);
    drain();
  endtask

  task automatic t_stream();
    int w;
    cur_tag = "R7";
    for (int i = 0; i < 8; i++) begin
      send((i * 5) % NR, (i * 3 + 2) % NR, i + 1, w);
      chk("R7", "cycles to accept in stream", w, 1);
    end
    drain();
  endtask

  task automatic t_stall();
    int w;
    int held;
    cur_tag = "R8";
    out_full = 1'b1;
    send(2, 13, 4, w);
    send(2, 13, 4, w);
    in_valid = 1'b1; in_src = 4'd2; in_dst = 4'd13; in_size = 4'd4;
    held = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (i == 0) held = int'(out_latency);
      chk("R8", "push while full", int'(out_push), 0);
      chk("R8", "pop while stalled", int'(in_pop), 0);
      chk("R8", "held latency", int'(out_latency), held);
      @(negedge clk);
    end
    out_full = 1'b0;
    send(2, 13, 4, w);
    send(13, 2, 1, w);
    drain();
  endtask

  task automatic t_rewrite();
    int w;
    cur_tag = "R9";
    for (int a = 0; a < 16; a++) write_curve(1'b0, 9, a, 3000 + a * 17);
    write_curve(1'b1, 8, idx_of(mload[8]), 4321);
    send(8, 10, 2, w);
    drain();
  endtask

  task automatic t_saturate();
    int w;
    cur_tag = "R6";
    for (int i = 0; i < 80; i++) send(15, 15, 15, w);
    drain();
  endtask

  initial begin
    t_reset();
    t_fill();
    t_self();
    t_paths();
    t_forward();
    t_stream();
    t_stall();
    t_rewrite();
    t_saturate();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule